// File: doc/BRIEF.md
# Pattern-Scan Colour Expansion Writer

This block forms the data for one video-memory word on each step of a graphic drawing operation. It holds a pattern store of sixteen 16-bit rows, two palette colours, a bitwise write mask and a scan window. Each step reads the pattern element at the scan pointer and turns it into a 16-bit word. In binary mode the element is one bit, which picks one of the two palette colours. In colour mode the element is a 4-bit colour taken from one of four 4x4 segments of the store, replicated across the word. The word is then merged with the old memory word under the mask, and the scan pointer advances.

A host loads the registers through a write-only register port. The drawing engine raises `stepValid` once per memory word and supplies the old word. With `stepStart` high the scan begins again at the programmed origin. With it low the scan resumes from where the previous step left it, so a pattern stays continuous across separate drawing commands.

Top module: `pat_expand_writer`

## Requirements
- R1: After reset `newValid` is 0, `newWord` is 0, `scanX` and `scanY` are 0, the mask is all ones, both colours are 0 and the shape selects binary mode with a 1x1 window.
- R2: The register map is as follows. A write to address 0x00..0x0F loads pattern row equal to the address. 0x10 loads colour zero, 0x11 loads colour one and 0x12 loads the mask. 0x13 loads the origin: start X in bits 7:4 and start Y in bits 15:12. 0x14 loads the shape: width minus 1 in bits 3:0, height minus 1 in bits 11:8 and colour mode in bit 15 (1 = colour).
- R3: In binary mode the element at (x, y) is bit x of pattern row y. A 0 produces colour zero and a 1 produces colour one.
- R4: In colour mode the segment number s is start-Y bits 3:2. The element at pointer (x, y) is the nibble at bits 4*x[1:0]+3 .. 4*x[1:0] of pattern row 4*s + y[1:0]. That nibble is repeated in all four nibbles of the word.
- R5: The result is (old AND NOT mask) OR (expanded AND mask), so every bit whose mask bit is 0 keeps the value of `oldWord`.
- R6: `newWord` and `newValid` are registered. A step presented on one clock edge produces them after that edge, and `newValid` is high for exactly one cycle per step.
- R7: The element used is the origin when `stepStart` is 1 and the current pointer otherwise. After the step, X moves to the element's X plus 1, or wraps to start X when it equals start X plus width minus 1 (4-bit arithmetic). `scanX`/`scanY` show the pointer after the step.
- R8: When X wraps, Y moves to the element's Y plus 1, or wraps to start Y when it equals start Y plus height minus 1. Y is unchanged otherwise.
- R9: A step with `stepStart` 0 resumes from the stored pointer even after register writes between commands, including a rewrite of the origin.
- R10: Without a step the pointer does not change and `newValid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 5 | Register write address |
| regWdata | input | 16 | Register write data |
| stepValid | input | 1 | Produce one output word this cycle |
| stepStart | input | 1 | Use the origin instead of the stored pointer |
| oldWord | input | 16 | Word read from video memory |
| newWord | output | 16 | Merged word to write back |
| newValid | output | 1 | newWord is valid this cycle |
| scanX | output | 4 | Scan pointer X after the last step |
| scanY | output | 4 | Scan pointer Y after the last step |

## Verification
Every result of a step (`newWord`, `newValid`, `scanX`, `scanY`) is due one clock edge after the edge at which `stepValid` is seen. The bench drives a step at a falling edge, removes it at the next falling edge and samples all four outputs at that moment, which lies half a cycle after the one register stage. A register write needs one edge to take effect, so the bench issues each write a full cycle before any step that depends on it. During idle cycles it checks that `newValid` is low and that the pointer has not moved.

// File: rtl/pat_expand_pkg.sv
package pat_expand_pkg;
  localparam int WORD_W    = 16;
  localparam int ROWS      = 16;
  localparam int IDX_W     = $clog2(ROWS);
  localparam int ADDR_W    = IDX_W + 1;
  localparam int NIB_W     = 4;
  localparam int NIBS      = WORD_W / NIB_W;
  localparam int SEG_SIDE  = 4;
  localparam int SEG_IDX_W = $clog2(SEG_SIDE);
  localparam int SEG_SEL_W = IDX_W - SEG_IDX_W;

  localparam logic [ADDR_W-1:0] ADDR_COL0   = ADDR_W'(16);
  localparam logic [ADDR_W-1:0] ADDR_COL1   = ADDR_W'(17);
  localparam logic [ADDR_W-1:0] ADDR_MASK   = ADDR_W'(18);
  localparam logic [ADDR_W-1:0] ADDR_ORIGIN = ADDR_W'(19);
  localparam logic [ADDR_W-1:0] ADDR_SHAPE  = ADDR_W'(20);

  typedef struct packed {
    logic                 ramWe;
    logic [IDX_W-1:0]     ramRow;
    logic                 colZeroWe;
    logic                 colOneWe;
    logic                 maskWe;
    logic                 stepFire;
    logic                 colourMode;
    logic [IDX_W-1:0]     elemX;
    logic [IDX_W-1:0]     elemY;
    logic [SEG_SEL_W-1:0] segSel;
  } ctlStrobes_t;
endpackage

// File: rtl/pat_expand_ctrl.sv
module pat_expand_ctrl
  import pat_expand_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WORD_W-1:0] regWdata,
  input  logic              stepValid,
  input  logic              stepStart,
  output ctlStrobes_t       strobes,
  output logic [IDX_W-1:0]  scanX,
  output logic [IDX_W-1:0]  scanY
);
  logic [IDX_W-1:0] startX, startY, spanX, spanY;
  logic             colourModeQ;
  logic [IDX_W-1:0] ptrX, ptrY;
  logic [IDX_W-1:0] elemX, elemY, endX, endY, nextX, nextY;

  // origin and shape registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startX      <= '0;
      startY      <= '0;
      spanX       <= '0;
      spanY       <= '0;
      colourModeQ <= 1'b0;
    end else if (regWe) begin
      case (regAddr)
        ADDR_ORIGIN: begin
          startX <= regWdata[7:4];
          startY <= regWdata[15:12];
        end
        ADDR_SHAPE: begin
          spanX       <= regWdata[3:0];
          spanY       <= regWdata[11:8];
          colourModeQ <= regWdata[15];
        end
        default: ;
      endcase
    end
  end

  // element selection and pointer advance
  always_comb begin
    elemX = stepStart ? startX : ptrX;
    elemY = stepStart ? startY : ptrY;
    endX  = startX + spanX;
    endY  = startY + spanY;
    if (elemX == endX) begin
      nextX = startX;
      nextY = (elemY == endY) ? startY : elemY + IDX_W'(1);
    end else begin
      nextX = elemX + IDX_W'(1);
      nextY = elemY;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrX <= '0;
      ptrY <= '0;
    end else if (stepValid) begin
      ptrX <= nextX;
      ptrY <= nextY;
    end
  end

  always_comb begin
    strobes            = '0;
    strobes.ramWe      = regWe && !regAddr[ADDR_W-1];
    strobes.ramRow     = regAddr[IDX_W-1:0];
    strobes.colZeroWe  = regWe && (regAddr == ADDR_COL0);
    strobes.colOneWe   = regWe && (regAddr == ADDR_COL1);
    strobes.maskWe     = regWe && (regAddr == ADDR_MASK);
    strobes.stepFire   = stepValid;
    strobes.colourMode = colourModeQ;
    strobes.elemX      = elemX;
    strobes.elemY      = elemY;
    strobes.segSel     = startY[IDX_W-1 -: SEG_SEL_W];
  end

  assign scanX = ptrX;
  assign scanY = ptrY;
endmodule

// File: rtl/pat_expand_datapath.sv
module pat_expand_datapath
  import pat_expand_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [WORD_W-1:0] regWdata,
  input  logic [WORD_W-1:0] oldWord,
  output logic [WORD_W-1:0] newWord,
  output logic              newValid
);
  logic [WORD_W-1:0] patRows [ROWS];
  logic [WORD_W-1:0] colZeroQ, colOneQ, maskQ;
  logic              patBit;
  logic [WORD_W-1:0] segRow;
  logic [NIB_W-1:0]  segNib;
  logic [WORD_W-1:0] colourWord, expandWord, mergedWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < ROWS; r++) patRows[r] <= '0;
    end else if (strobes.ramWe) begin
      patRows[strobes.ramRow] <= regWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colZeroQ <= '0;
      colOneQ  <= '0;
      maskQ    <= '1;
    end else begin
      if (strobes.colZeroWe) colZeroQ <= regWdata;
      if (strobes.colOneWe)  colOneQ  <= regWdata;
      if (strobes.maskWe)    maskQ    <= regWdata;
    end
  end

  // binary element and colour-segment element
  always_comb begin
    patBit = patRows[strobes.elemY][strobes.elemX];
    segRow = patRows[{strobes.segSel, strobes.elemY[SEG_IDX_W-1:0]}];
    segNib = segRow[strobes.elemX[SEG_IDX_W-1:0] * NIB_W +: NIB_W];
  end

  for (genvar g = 0; g < NIBS; g++) begin : g_rep
    assign colourWord[g*NIB_W +: NIB_W] = segNib;
  end

  always_comb begin
    if (strobes.colourMode) expandWord = colourWord;
    else                    expandWord = patBit ? colOneQ : colZeroQ;
    mergedWord = (oldWord & ~maskQ) | (expandWord & maskQ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      newWord  <= '0;
      newValid <= 1'b0;
    end else begin
      newValid <= strobes.stepFire;
      if (strobes.stepFire) newWord <= mergedWord;
    end
  end
endmodule

// File: rtl/pat_expand_writer.sv
module pat_expand_writer
  import pat_expand_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WORD_W-1:0] regWdata,
  input  logic              stepValid,
  input  logic              stepStart,
  input  logic [WORD_W-1:0] oldWord,
  output logic [WORD_W-1:0] newWord,
  output logic              newValid,
  output logic [IDX_W-1:0]  scanX,
  output logic [IDX_W-1:0]  scanY
);
  ctlStrobes_t strobes;

  pat_expand_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .stepValid(stepValid), .stepStart(stepStart),
    .strobes(strobes), .scanX(scanX), .scanY(scanY)
  );

  pat_expand_datapath dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .regWdata(regWdata),
    .oldWord(oldWord), .newWord(newWord), .newValid(newValid)
  );
endmodule

// File: rtl/pat_expand_sva.sv
module pat_expand_sva
  import pat_expand_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              stepValid,
  input logic [WORD_W-1:0] oldWord,
  input logic [WORD_W-1:0] newWord,
  input logic              newValid,
  input logic [IDX_W-1:0]  scanX,
  input logic [IDX_W-1:0]  scanY,
  input logic [WORD_W-1:0] maskQ,
  input logic [WORD_W-1:0] colZeroQ,
  input logic [WORD_W-1:0] colOneQ,
  input logic              colourMode
);
  // R6: a step yields a valid word on the next cycle
  a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    stepValid |=> newValid);

  // R6 / R10: no valid word without a step
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !stepValid |=> !newValid);

  // R10: pointer holds while idle
  a_r10_ptr_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stepValid |=> $stable({scanX, scanY}));

  // R5: masked-off bits follow the old word
  a_r5_mask_keep: assert property (@(posedge clk) disable iff (!rstN)
    stepValid |=> ((newWord ^ $past(oldWord)) & ~$past(maskQ)) == '0);

  // R3: in binary mode the enabled bits come from one palette entry
  a_r3_palette_only: assert property (@(posedge clk) disable iff (!rstN)
    (stepValid && !colourMode) |=>
      (((newWord & $past(maskQ)) == ($past(colZeroQ) & $past(maskQ))) ||
       ((newWord & $past(maskQ)) == ($past(colOneQ)  & $past(maskQ)))));
endmodule

bind pat_expand_writer pat_expand_sva chk_i (
  .clk(clk), .rstN(rstN), .stepValid(stepValid), .oldWord(oldWord),
  .newWord(newWord), .newValid(newValid), .scanX(scanX), .scanY(scanY),
  .maskQ(dp_i.maskQ), .colZeroQ(dp_i.colZeroQ), .colOneQ(dp_i.colOneQ),
  .colourMode(ctrl_i.colourModeQ)
);

// File: tb/pat_expand_writer_tb.sv
module pat_expand_writer_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [15:0] regWdata = '0;
  logic        stepValid = 1'b0;
  logic        stepStart = 1'b0;
  logic [15:0] oldWord = '0;
  logic [15:0] newWord;
  logic        newValid;
  logic [3:0]  scanX, scanY;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // bench model of programmed state
  logic [15:0] mRam [16];
  logic [15:0] mC0 = '0, mC1 = '0, mMask = '1;
  logic [3:0]  mSx = '0, mSy = '0, mWx = '0, mHy = '0;
  logic        mCol = 1'b0;
  logic [3:0]  mPx = '0, mPy = '0;
  logic [31:0] seed = 32'h1234_5678;

  always #4 clk = ~clk;

  pat_expand_writer dut_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .stepValid(stepValid), .stepStart(stepStart),
    .oldWord(oldWord), .newWord(newWord), .newValid(newValid),
    .scanX(scanX), .scanY(scanY)
  );

  function automatic logic [15:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[30:15];
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
    if (!a[4]) mRam[a[3:0]] = d;
    else case (a)
      5'h10: mC0 = d;
      5'h11: mC1 = d;
      5'h12: mMask = d;
      5'h13: begin mSx = d[7:4]; mSy = d[15:12]; end
      5'h14: begin mWx = d[3:0]; mHy = d[11:8]; mCol = d[15]; end
      default: ;
    endcase
  endtask

  task automatic step(input logic st, input logic [15:0] old);
    logic [3:0]  ix, iy, ex, ey;
    logic [15:0] nw, exp;
    logic [3:0]  nib;
    ix = st ? mSx : mPx;
    iy = st ? mSy : mPy;
    if (mCol) begin
      nib = mRam[{mSy[3:2], iy[1:0]}][ix[1:0]*4 +: 4];
      nw = {4{nib}};
    end else begin
      nw = mRam[iy][ix] ? mC1 : mC0;
    end
    exp = (old & ~mMask) | (nw & mMask);
    ex = mSx + mWx;
    ey = mSy + mHy;
    if (ix == ex) begin
      mPx = mSx;
      mPy = (iy == ey) ? mSy : iy + 4'd1;
    end else begin
      mPx = ix + 4'd1;
      mPy = iy;
    end
    @(negedge clk);
    stepValid = 1'b1; stepStart = st; oldWord = old;
    @(negedge clk);
    stepValid = 1'b0; stepStart = 1'b0;
    chk("R6 newValid", {15'd0, newValid}, 16'd1);
    chk(mCol ? "R4/R5 colour word" : "R3/R5 binary word", newWord, exp);
    chk("R7 scanX", {12'd0, scanX}, {12'd0, mPx});
    chk("R8 scanY", {12'd0, scanY}, {12'd0, mPy});
  endtask

  task automatic run(input int n);
    step(1'b1, rnd());
    for (int k = 1; k < n; k++) step(1'b0, rnd());
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < 16; r++) mRam[r] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 newValid", {15'd0, newValid}, 16'd0);
    chk("R1 newWord", newWord, 16'd0);
    chk("R1 scanX", {12'd0, scanX}, 16'd0);
    chk("R1 scanY", {12'd0, scanY}, 16'd0);
    // R1: reset mask all ones, colours zero, binary 1x1 window
    step(1'b1, 16'hBEEF);

    // R2 load pattern and palette
    for (int r = 0; r < 16; r++) wr(r[4:0], rnd());
    wr(5'h10, 16'h1234);
    wr(5'h11, 16'hFEDC);

    // R3 R7 R8 binary sweep over origins, sizes and masks
    foreach (mSx[i]) ;
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 2; b++)
        for (int w = 0; w < 3; w++)
          for (int h = 0; h < 2; h++) begin
            logic [3:0] sx, sy, wx, hy;
            sx = (a == 0) ? 4'd0 : (a == 1) ? 4'd5 : 4'd13;
            sy = (b == 0) ? 4'd0 : 4'd9;
            wx = (w == 0) ? 4'd0 : (w == 1) ? 4'd3 : 4'd15;
            hy = (h == 0) ? 4'd1 : 4'd15;
            wr(5'h12, (h == 0) ? 16'hFFFF : rnd());
            wr(5'h13, {sy, 4'h0, sx, 4'h0});
            wr(5'h14, {4'h0, hy, 4'h0, wx});
            run((int'(wx) + 1) * (int'(hy) + 1) + 3);
          end

    // R4 colour mode, every segment, several windows
    wr(5'h12, 16'hFFFF);
    for (int s = 0; s < 4; s++)
      for (int v = 0; v < 3; v++) begin
        logic [3:0] sx;
        sx = (v == 0) ? 4'd0 : (v == 1) ? 4'd2 : 4'd7;
        wr(5'h13, {s[1:0], 2'd1, 4'h0, sx, 4'h0});
        wr(5'h14, (v == 2) ? 16'h8201 : 16'h8303);
        run(20);
      end
    wr(5'h12, 16'h0F0F);
    run(10);

    // R9 continuity across a palette change and an origin rewrite
    wr(5'h12, 16'hFFFF);
    wr(5'h13, 16'h3040);
    wr(5'h14, 16'h0202);
    run(4);
    wr(5'h10, 16'h0BAD);
    wr(5'h11, 16'hCAFE);
    for (int k = 0; k < 5; k++) step(1'b0, rnd());
    begin
      logic [3:0] hx, hy;
      hx = mPx; hy = mPy;
      wr(5'h13, 16'h0000);
      chk("R9 scanX after origin write", {12'd0, scanX}, {12'd0, hx});
      chk("R9 scanY after origin write", {12'd0, scanY}, {12'd0, hy});
      step(1'b0, rnd());
    end

    // R10 idle: pointer holds, no valid
    begin
      logic [3:0] hx, hy;
      hx = mPx; hy = mPy;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        chk("R10 newValid idle", {15'd0, newValid}, 16'd0);
        chk("R10 scanX idle", {12'd0, scanX}, {12'd0, hx});
        chk("R10 scanY idle", {12'd0, scanY}, {12'd0, hy});
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule